// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Wake-up Filter

This block receives asynchronous serial frames on one input line. An external strobe, active for one clock cycle sixteen times per bit period, paces the receiver. The line is first brought into the clock domain by a short flop chain. The block then looks for a high-to-low transition while it is idle and both of its enables are set. Each bit slot is divided into sixteen sample slots. The bit value is the majority of the 7th, 8th and 9th samples, which rejects short noise spikes. A start slot that votes high is treated as a false start, and the receiver returns to idle.

Two frame formats are supported: eight data bits, or eight data bits followed by a ninth bit. Bits arrive least significant first. At the vote point of the stop slot, the collected bits are written to a 9-bit receive buffer and a one-cycle receive pulse is raised. The pulse is raised even when the stop slot votes low, and in that case a separate error pulse comes with it. In wake-up mode with 9-bit frames, only frames whose ninth bit is 1 reach the buffer. All other frames are dropped without any pulse, which lets a node on a shared line ignore data meant for other nodes until it is addressed.

Clearing the receive enable does not cut off a frame that is already in progress. That frame still completes, and no later start is accepted.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_buf is 0 and rx_irq and stop_err are low.
- R2: A frame starts only on a falling edge of rxd seen while in idle with both run_en and rx_en high. With run_en low, a full frame on the line changes neither rx_buf nor rx_irq.
- R3: If the start slot votes 1, the frame is abandoned without any pulse, and a valid frame that follows is received normally.
- R4: Each bit is the majority of samples 7, 8 and 9 of its 16-sample slot, where sample 1 is the first baud strobe after the line changes. A wrong level on sample 8 alone does not change the bit. Wrong levels on samples 7 and 8 together do change it.
- R5: With nine_bit=0, eight data bits are taken LSB first into rx_buf[7:0], and rx_buf[8] is 0.
- R6: With nine_bit=1, the ninth received bit lands in rx_buf[8].
- R7: rx_irq is a one-cycle pulse, high in the clock cycle after the edge that takes the 9th sample of the stop slot. rx_buf takes its new value in that same cycle and changes at no other time.
- R8: When the stop slot votes 0, rx_irq still pulses and stop_err pulses in the same cycle. stop_err never pulses without rx_irq.
- R9: Clearing rx_en during a frame lets that frame deliver its data and pulse. Frames whose start comes later are ignored.
- R10: With wake_mode=1 and nine_bit=1, a frame whose ninth bit is 0 leaves rx_buf unchanged and raises neither rx_irq nor stop_err. A frame whose ninth bit is 1 is delivered.
- R11: With wake_mode=1 and nine_bit=0, frames are delivered as in R5, with no filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| run_en | input | 1 | Receiver run enable |
| rx_en | input | 1 | Receive enable (start acceptance) |
| wake_mode | input | 1 | Drop 9-bit frames whose ninth bit is 0 |
| nine_bit | input | 1 | Frame format: 0 = 8 data bits, 1 = 9 bits |
| rx_buf | output | 9 | Receive data buffer |
| rx_irq | output | 1 | Receive pulse, one cycle |
| stop_err | output | 1 | Stop-slot error pulse, one cycle |

## Verification
The bench first sends clean 8-bit and 9-bit frames with asymmetric data patterns, which exposes bit-order or bit-count mistakes. It then injects noise on a single sample or on two adjacent samples inside the vote window. These two cases tell true majority voting apart from taking a single sample or from an off-by-one window. A short low pulse on the line separates start validation from plain edge triggering, and a low stop slot shows that the pulse still comes and the error flag is raised. The wake-up, enable-off and enable-cleared-mid-frame cases separate filtering and gating from ordinary reception, and each is checked through the buffer contents and the pulse counts.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic nine;
        logic wake;
    } frame_cfg_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // A frame is delivered unless wake filtering applies and its ninth bit is clear
    function automatic logic frame_kept(input frame_cfg_t cfg, input logic top_bit);
        return !(cfg.wake && cfg.nine && !top_bit);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            last_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], din};
            last_q <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int FIRST_SMP = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick,
    input  logic din,
    output logic vote_ok,
    output logic vote_bit,
    output logic bit_end
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] P_A    = CNT_W'(FIRST_SMP);
    localparam logic [CNT_W-1:0] P_B    = CNT_W'(FIRST_SMP + 1);
    localparam logic [CNT_W-1:0] P_C    = CNT_W'(FIRST_SMP + 2);
    localparam logic [CNT_W-1:0] P_LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt;
    logic             smp_a, smp_b;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (tick) begin
            cnt <= (cnt == P_LAST) ? '0 : cnt + 1'b1;
            if (cnt == P_A) smp_a <= din;
            if (cnt == P_B) smp_b <= din;
        end
    end

    assign vote_ok  = !hold && tick && (cnt == P_C);
    assign vote_bit = maj3(smp_a, smp_b, din);
    assign bit_end  = !hold && tick && (cnt == P_LAST);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int FIRST_SMP   = 6,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BUF_W      = DATA_BITS + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick,
    input  logic             rxd,
    input  logic             run_en,
    input  logic             rx_en,
    input  logic             wake_mode,
    input  logic             nine_bit,
    output logic [BUF_W-1:0] rx_buf,
    output logic             rx_irq,
    output logic             stop_err
);
    localparam int IDX_W = $clog2(BUF_W);
    localparam logic [IDX_W-1:0] IDX_NINE  = IDX_W'(BUF_W - 1);
    localparam logic [IDX_W-1:0] IDX_EIGHT = IDX_W'(BUF_W - 2);

    rx_state_e        state;
    frame_cfg_t       cfg;
    logic [IDX_W-1:0] idx;
    logic [BUF_W-1:0] shreg;
    logic             line_s, line_fall;
    logic             vote_ok, vote_bit, bit_end;
    logic [IDX_W-1:0] last_idx;
    logic             keep;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s),
        .fall (line_fall)
    );

    uart_rx_sampler #(.OSR(OSR), .FIRST_SMP(FIRST_SMP)) u_smp (
        .clk      (clk),
        .rst      (rst),
        .hold     (state == RX_IDLE),
        .tick     (baud_tick),
        .din      (line_s),
        .vote_ok  (vote_ok),
        .vote_bit (vote_bit),
        .bit_end  (bit_end)
    );

    assign last_idx = cfg.nine ? IDX_NINE : IDX_EIGHT;
    assign keep     = frame_kept(cfg, shreg[BUF_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cfg      <= '0;
            idx      <= '0;
            shreg    <= '0;
            rx_buf   <= '0;
            rx_irq   <= 1'b0;
            stop_err <= 1'b0;
        end else begin
            rx_irq   <= 1'b0;
            stop_err <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (line_fall && run_en && rx_en) begin
                        state    <= RX_START;
                        cfg.nine <= nine_bit;
                        cfg.wake <= wake_mode;
                        idx      <= '0;
                        shreg    <= '0;
                    end
                end
                RX_START: begin
                    if (vote_ok && vote_bit) state <= RX_IDLE;
                    else if (bit_end)        state <= RX_DATA;
                end
                RX_DATA: begin
                    if (vote_ok) shreg[idx] <= vote_bit;
                    if (bit_end) begin
                        if (idx == last_idx) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (vote_ok) begin
                        if (keep) rx_buf <= shreg;
                        rx_irq   <= keep;
                        stop_err <= keep & ~vote_bit;
                        state    <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk
    import uart_rx_pkg::*;
#(
    parameter int BUF_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             rx_en,
    input logic [BUF_W-1:0] rx_buf,
    input logic             rx_irq,
    input logic             stop_err,
    input rx_state_e        state,
    input logic             frame_nine
);
    a_r8_err_implies_irq: assert property (@(posedge clk) disable iff (rst)
        stop_err |-> rx_irq);

    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    a_r7_buf_only_on_irq: assert property (@(posedge clk) disable iff (rst)
        !rx_irq |-> $stable(rx_buf));

    a_r7_irq_from_stop: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $past(state) == RX_STOP);

    a_r2_start_gated: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && !(run_en && rx_en)) |=> state == RX_IDLE);

    a_r5_bit8_clear: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && !frame_nine) |-> rx_buf[BUF_W-1] == 1'b0);
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.BUF_W(BUF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .rx_en      (rx_en),
    .rx_buf     (rx_buf),
    .rx_irq     (rx_irq),
    .stop_err   (stop_err),
    .state      (state),
    .frame_nine (cfg.nine)
);

// File: tb/tb_uart_wake_rx.sv
module tb_uart_wake_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       run_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       wake_mode = 1'b0;
    logic       nine_bit = 1'b0;
    logic [8:0] rx_buf;
    logic       rx_irq;
    logic       stop_err;

    int vectors = 0;
    int misses  = 0;
    int irq_cnt = 0;
    int err_cnt = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_wake_rx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .run_en(run_en), .rx_en(rx_en), .wake_mode(wake_mode), .nine_bit(nine_bit),
        .rx_buf(rx_buf), .rx_irq(rx_irq), .stop_err(stop_err)
    );

    always @(negedge clk) begin
        if (!rst && rx_irq)   irq_cnt++;
        if (!rst && stop_err) err_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one sample slot: line level set just after a negedge, strobe seen at the 8th edge
    task automatic tk(input logic v);
        @(negedge clk);
        rxd = v;
        baud_tick = 1'b0;
        repeat (6) @(negedge clk);
        @(negedge clk);
        baud_tick = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tk(1'b1);
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    // slot 0 = start, 1..n = data, n+1 = stop; mask bit i corrupts sample i+1 of slot gslot
    task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopv,
                              input int gslot, input logic [15:0] gmask,
                              input int drop_slot, input logic exp_irq, input string req);
        int nb;
        logic v;
        nb = nine ? 9 : 8;
        nine_bit = nine;
        for (int s = 0; s <= nb + 1; s++) begin
            if (s == drop_slot) rx_en = 1'b0;
            if (s == 0)           v = 1'b0;
            else if (s <= nb)     v = d[s-1];
            else                  v = stopv;
            if (s == nb + 1) begin
                for (int i = 0; i < 9; i++) tk(v);
                check({req, " R7 no pulse before 9th stop sample"}, int'(rx_irq), 0);
                @(posedge clk);
                #1;
                check({req, " R7 pulse after 9th stop sample"}, int'(rx_irq), int'(exp_irq));
                for (int i = 9; i < 16; i++) tk(v);
            end else begin
                for (int i = 0; i < 16; i++)
                    tk(v ^ ((s == gslot) ? gmask[i] : 1'b0));
            end
        end
        idle(8);
    endtask

    task automatic t_reset;
        check("R1 buffer after reset", int'(rx_buf), 0);
        check("R1 irq after reset", int'(rx_irq), 0);
        check("R1 err after reset", int'(stop_err), 0);
    endtask

    task automatic t_basic;
        int i0 = irq_cnt, e0 = err_cnt;
        send_frame(9'h0A5, 1'b0, 1'b1, -1, 16'h0, -1, 1'b1, "R5");
        check("R5 8-bit data LSB first", int'(rx_buf), 'h0A5);
        check("R7 one pulse per frame", irq_cnt - i0, 1);
        check("R8 no error on good stop", err_cnt - e0, 0);
        send_frame(9'h0C3, 1'b0, 1'b1, -1, 16'h0, -1, 1'b1, "R5");
        check("R5 second pattern", int'(rx_buf), 'h0C3);
    endtask

    task automatic t_nine;
        send_frame(9'h1F0, 1'b1, 1'b1, -1, 16'h0, -1, 1'b1, "R6");
        check("R6 ninth bit in buffer bit 8", int'(rx_buf), 'h1F0);
        send_frame(9'h00F, 1'b1, 1'b1, -1, 16'h0, -1, 1'b1, "R6");
        check("R6 ninth bit clear", int'(rx_buf), 'h00F);
    endtask

    task automatic t_false_start;
        int i0 = irq_cnt;
        tk(1'b0); tk(1'b0); tk(1'b0);
        idle(40);
        check("R3 false start gives no pulse", irq_cnt - i0, 0);
        check("R3 buffer kept after false start", int'(rx_buf), 'h00F);
        send_frame(9'h05A, 1'b0, 1'b1, -1, 16'h0, -1, 1'b1, "R3");
        check("R3 frame after false start", int'(rx_buf), 'h05A);
    endtask

    task automatic t_majority;
        send_frame(9'h03C, 1'b0, 1'b1, 1, 16'h0080, -1, 1'b1, "R4");
        check("R4 sample 8 glitch outvoted", int'(rx_buf), 'h03C);
        send_frame(9'h03C, 1'b0, 1'b1, 1, 16'h00C0, -1, 1'b1, "R4");
        check("R4 samples 7+8 flip bit 0", int'(rx_buf), 'h03D);
        send_frame(9'h03C, 1'b0, 1'b1, 3, 16'hFE3F, -1, 1'b1, "R4");
        check("R4 samples outside window ignored", int'(rx_buf), 'h03C);
    endtask

    task automatic t_bad_stop;
        int i0 = irq_cnt, e0 = err_cnt;
        send_frame(9'h066, 1'b0, 1'b0, -1, 16'h0, -1, 1'b1, "R8");
        check("R8 pulse despite bad stop", irq_cnt - i0, 1);
        check("R8 error pulse on bad stop", err_cnt - e0, 1);
        check("R8 data still delivered", int'(rx_buf), 'h066);
    endtask

    task automatic t_run_off;
        int i0 = irq_cnt;
        run_en = 1'b0;
        send_frame(9'h099, 1'b0, 1'b1, -1, 16'h0, -1, 1'b0, "R2");
        check("R2 no pulse with run_en low", irq_cnt - i0, 0);
        check("R2 buffer unchanged with run_en low", int'(rx_buf), 'h066);
        run_en = 1'b1;
    endtask

    task automatic t_rx_en_mid;
        int i0 = irq_cnt;
        send_frame(9'h081, 1'b0, 1'b1, -1, 16'h0, 3, 1'b1, "R9");
        check("R9 frame completes after rx_en cleared", int'(rx_buf), 'h081);
        check("R9 pulse of finished frame", irq_cnt - i0, 1);
        send_frame(9'h042, 1'b0, 1'b1, -1, 16'h0, -1, 1'b0, "R9");
        check("R9 later frame ignored", int'(rx_buf), 'h081);
        check("R9 no pulse for later frame", irq_cnt - i0, 1);
        rx_en = 1'b1;
    endtask

    task automatic t_wake;
        int i0 = irq_cnt, e0 = err_cnt;
        wake_mode = 1'b1;
        send_frame(9'h055, 1'b1, 1'b0, -1, 16'h0, -1, 1'b0, "R10");
        check("R10 ninth bit 0 dropped, buffer kept", int'(rx_buf), 'h081);
        check("R10 no pulse for dropped frame", irq_cnt - i0, 0);
        check("R10 no error for dropped frame", err_cnt - e0, 0);
        send_frame(9'h1AA, 1'b1, 1'b1, -1, 16'h0, -1, 1'b1, "R10");
        check("R10 ninth bit 1 delivered", int'(rx_buf), 'h1AA);
        check("R10 pulse for address frame", irq_cnt - i0, 1);
    endtask

    task automatic t_wake8;
        int i0 = irq_cnt;
        send_frame(9'h033, 1'b0, 1'b1, -1, 16'h0, -1, 1'b1, "R11");
        check("R11 8-bit frame unfiltered", int'(rx_buf), 'h033);
        check("R11 pulse in 8-bit wake mode", irq_cnt - i0, 1);
        wake_mode = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle(4);
        t_basic();
        t_nine();
        t_false_start();
        t_majority();
        t_bad_stop();
        t_run_off();
        t_rx_en_mid();
        t_wake();
        t_wake8();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule